// File: doc/BRIEF.md
# Burst Pseudo-SRAM Bus Controller

This controller sits between a host and a pseudo-SRAM that shares one set of control strobes between two kinds of access. Reads are synchronous bursts: the controller pulses the address-latch strobe for one clock, then relies on the memory's WAIT# line to learn when each data word is on the bus. Writes are asynchronous single words: the strobes are held for a fixed number of system clocks with the address set up before, and held after, the write pulse.

The host issues one request at a time through a valid/ready pair, carrying a write flag, an address, write data and two byte enables. A read returns four words in ascending address order, each with a one-cycle valid pulse, followed by a done pulse. The controller counts the read latency and the burst beats. It ignores WAIT# whenever chip select is high, and it caps how long chip select stays low so that the burst-cycle limit is never exceeded. It also leaves dead cycles between operations, so that the data bus turns around cleanly and the write strobe recovers before the next read.

The memory clock output is the system clock, and all memory-side strobes are registered on its rising edge. The memory samples them on the following rising edge.

Top module: `psram_burst_ctrl`

## Requirements
- R1: After reset, and whenever no operation is in progress, `ready` is 1, every active-low strobe is 1, `mem_dq_oe` is 0 and `rd_valid`/`rd_done` are 0. A request is taken only on a rising edge where `ready` and `req_valid` are both 1.
- R2: After a read is accepted, the next cycle has CS#, ADV#, LB# and UB# low with `mem_addr` equal to the request address. ADV# stays low for exactly that one cycle. From the cycle after, OE# is low and `mem_dq_oe` is 0.
- R3: A word is captured only on an edge where WAIT# is sampled high while CS# is low. Each capture gives `rd_valid` = 1 in the next cycle with that word. Words come in ascending address order (base, base+1, ...). Each cycle that WAIT# is low between beats delays the remaining beats by one cycle.
- R4: A read delivers exactly BURST_LEN (4) words. CS# and OE# are high in the cycle of the last `rd_valid`, and `rd_done` pulses for one cycle right after it, with `rd_timeout` = 0.
- R5: WAIT# and DQ are ignored while CS# is high: no `rd_valid` ever appears outside a burst, however WAIT# moves.
- R6: No word is captured before the LATENCY-th (5th) edge after the edge that samples ADV# low. With a memory that raises WAIT# on the edge at latency minus one, the first `rd_valid` is high in the sixth cycle counted from the ADV# low cycle (that cycle being cycle 0).
- R7: CS# is never low for more than MAX_BURST_CYC (125) consecutive cycles, which is 2.5 µs at 50 MHz. If a burst is still incomplete at that point, CS# rises after exactly 125 low cycles, and `rd_done` and `rd_timeout` pulse together in the next cycle.
- R8: After a write is accepted, the first cycle has CS# low, WE# high, LB# = ~be[0] and UB# = ~be[1]. Then WE# is low for WR_PULSE_CYC (3) cycles, then one hold cycle follows with WE# high and CS# still low, then all strobes go high. `mem_addr` is constant throughout, and only the enabled bytes are written.
- R9: `mem_dq_oe` is 1 only during the WE# low cycles and the hold cycle, and `mem_dq_o` then carries the request data. `mem_dq_oe` is never 1 while OE# is low.
- R10: In the cycle of the final `rd_valid`, `ready` is 0 and CS# is high. This gives one bus-turnaround cycle before any following request can be taken.
- R11: WE# has been high for at least one full clock whenever ADV# is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = single-word write, 0 = burst read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte, bit 1 = high byte |
| ready | output | 1 | Controller idle, request can be taken |
| rd_data | output | DATA_W | Read word |
| rd_valid | output | 1 | One-cycle strobe per read word |
| rd_done | output | 1 | One-cycle strobe after a read ends |
| rd_timeout | output | 1 | With rd_done: burst was cut by the time limit |
| mem_clk | output | 1 | Memory clock |
| mem_adv_n | output | 1 | Address latch strobe, active low |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte enable, active low |
| mem_ub_n | output | 1 | High byte enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_o | output | DATA_W | Data driven to memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | DATA_W | Data from memory |
| mem_wait_n | input | 1 | Memory data-not-ready flag, active low |

## Verification
The assertions check the strobe relations on every cycle:
- ADV# is low for a single cycle, and only under CS#.
- The DQ drive window is tied to WE# and never overlaps OE#.
- The write address is stable, and WE# has recovered before ADV#.
- CS# low time stays under the limit, the beat count per burst is bounded, and no word arrives before the latency or without a sampled-high WAIT# under CS#.

Only the bench scenarios can show that the data words are the right ones and in address order, that byte enables reach the memory correctly, and how stalls in WAIT# shift the beat timing. They also cover the exact cycle of the forced end when WAIT# never rises.

// File: rtl/psram_burst_ctrl.sv
module psram_burst_ctrl #(
  parameter int ADDR_W        = 22,
  parameter int DATA_W        = 16,
  parameter int BURST_LEN     = 4,
  parameter int LATENCY       = 5,
  parameter int WR_PULSE_CYC  = 3,
  parameter int MAX_BURST_CYC = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_done,
  output logic              rd_timeout,
  output logic              mem_clk,
  output logic              mem_adv_n,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i,
  input  logic              mem_wait_n
);

  localparam int CMAX = (MAX_BURST_CYC > WR_PULSE_CYC) ? MAX_BURST_CYC : WR_PULSE_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int BW   = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_ADV, S_RD_WAIT, S_RD_END, S_WR_SETUP, S_WR_PULSE, S_WR_HOLD
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] beat;
  logic          cut;

  wire capture   = (state == S_RD_WAIT) && !mem_cs_n && mem_wait_n && (cnt >= CW'(LATENCY));
  wire last_beat = (beat == BW'(BURST_LEN - 1));
  wire limit_hit = (cnt == CW'(MAX_BURST_CYC - 1));

  assign ready   = (state == S_IDLE);
  assign mem_clk = clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      beat       <= '0;
      cut        <= 1'b0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
      rd_done    <= 1'b0;
      rd_timeout <= 1'b0;
      mem_adv_n  <= 1'b1;
      mem_cs_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_lb_n   <= 1'b1;
      mem_ub_n   <= 1'b1;
      mem_addr   <= '0;
      mem_dq_o   <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      rd_valid   <= 1'b0;
      rd_done    <= 1'b0;
      rd_timeout <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          mem_cs_n <= 1'b0;
          cnt      <= '0;
          beat     <= '0;
          if (req_write) begin
            mem_dq_o <= req_wdata;
            mem_lb_n <= ~req_be[0];
            mem_ub_n <= ~req_be[1];
            state    <= S_WR_SETUP;
          end else begin
            mem_adv_n <= 1'b0;
            mem_lb_n  <= 1'b0;
            mem_ub_n  <= 1'b0;
            state     <= S_RD_ADV;
          end
        end
        S_RD_ADV: begin
          mem_adv_n <= 1'b1;
          mem_oe_n  <= 1'b0;
          cnt       <= cnt + 1'b1;
          state     <= S_RD_WAIT;
        end
        S_RD_WAIT: begin
          cnt <= cnt + 1'b1;
          if (capture) begin
            rd_data  <= mem_dq_i;
            rd_valid <= 1'b1;
            beat     <= beat + 1'b1;
          end
          if ((capture && last_beat) || limit_hit) begin
            cut      <= !(capture && last_beat);
            mem_cs_n <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_lb_n <= 1'b1;
            mem_ub_n <= 1'b1;
            state    <= S_RD_END;
          end
        end
        S_RD_END: begin
          rd_done    <= 1'b1;
          rd_timeout <= cut;
          cut        <= 1'b0;
          state      <= S_IDLE;
        end
        S_WR_SETUP: begin
          mem_we_n  <= 1'b0;
          mem_dq_oe <= 1'b1;
          cnt       <= '0;
          state     <= S_WR_PULSE;
        end
        S_WR_PULSE: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(WR_PULSE_CYC - 1)) begin
            mem_we_n <= 1'b1;
            state    <= S_WR_HOLD;
          end
        end
        S_WR_HOLD: begin
          mem_cs_n  <= 1'b1;
          mem_lb_n  <= 1'b1;
          mem_ub_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/psram_burst_ctrl_chk.sv
module psram_burst_ctrl_chk #(
  parameter int ADDR_W        = 22,
  parameter int BURST_LEN     = 4,
  parameter int LATENCY       = 5,
  parameter int MAX_BURST_CYC = 125
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              rd_valid,
  input logic              rd_done,
  input logic              rd_timeout,
  input logic              mem_adv_n,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe,
  input logic              mem_wait_n
);

  localparam int LW = $clog2(MAX_BURST_CYC + 2);
  localparam int VW = $clog2(BURST_LEN + 2);
  localparam int SW = $clog2(LATENCY + 2);

  logic [LW-1:0] cs_low;
  logic [VW-1:0] vcnt;
  logic [SW-1:0] since_adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_low    <= '0;
      vcnt      <= '0;
      since_adv <= '0;
    end else begin
      cs_low <= mem_cs_n ? '0 : cs_low + 1'b1;
      if (rd_done)       vcnt <= '0;
      else if (rd_valid) vcnt <= vcnt + 1'b1;
      if (!mem_adv_n)                       since_adv <= SW'(1);
      else if (since_adv != '0 && since_adv <= SW'(LATENCY)) since_adv <= since_adv + 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_cs_n && mem_we_n && mem_oe_n && mem_adv_n && !mem_dq_oe));  // R1
  AST_ADV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |=> mem_adv_n);  // R2
  AST_ADV_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> !mem_cs_n);  // R2
  AST_CAPTURE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(mem_wait_n && !mem_cs_n && !mem_oe_n));  // R3 R5
  AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (vcnt < VW'(BURST_LEN)));  // R4
  AST_DONE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !rd_timeout) |-> (vcnt == VW'(BURST_LEN) && $past(rd_valid)));  // R4
  AST_NO_EARLY_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (since_adv == SW'(LATENCY + 1)));  // R6
  AST_CS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> (cs_low < LW'(MAX_BURST_CYC)));  // R7
  AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(!mem_cs_n) && $stable(mem_addr)));  // R8
  AST_WE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || $rose(mem_we_n)) |-> $stable(mem_addr));  // R8
  AST_DQ_NO_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_cs_n));  // R9
  AST_DQ_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> !mem_we_n);  // R9
  AST_DQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_we_n) && !mem_cs_n) |-> mem_dq_oe);  // R9
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> $past(!ready && mem_cs_n));  // R10
  AST_WE_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> (mem_we_n && $past(mem_we_n)));  // R11

endmodule

bind psram_burst_ctrl psram_burst_ctrl_chk #(
  .ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN), .LATENCY(LATENCY), .MAX_BURST_CYC(MAX_BURST_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .rd_valid(rd_valid), .rd_done(rd_done),
  .rd_timeout(rd_timeout), .mem_adv_n(mem_adv_n), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_oe(mem_dq_oe), .mem_wait_n(mem_wait_n)
);

// File: tb/psram_burst_ctrl_tb.sv
module psram_burst_ctrl_tb;
  localparam int ADDR_W = 22;
  localparam int DATA_W = 16;
  localparam int LAT    = 5;
  localparam int WP     = 3;
  localparam int MAXC   = 125;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [1:0] req_be = 2'b00;
  logic ready, rd_valid, rd_done, rd_timeout, mem_clk;
  logic [DATA_W-1:0] rd_data, mem_dq_o;
  logic mem_adv_n, mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_dq_i = '0;
  logic mem_wait_n = 1'b1;

  int tests = 0, fails = 0, cyc = 0;
  logic [15:0] marr [64];
  logic [15:0] expm [64];
  int m_ready_at = 4, m_stall = 0;

  always #10 clk = ~clk;

  psram_burst_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_LEN(4), .LATENCY(LAT),
                     .WR_PULSE_CYC(WP), .MAX_BURST_CYC(MAXC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .ready(ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_done(rd_done), .rd_timeout(rd_timeout),
    .mem_clk(mem_clk), .mem_adv_n(mem_adv_n), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i), .mem_wait_n(mem_wait_n));

  function automatic logic [15:0] init_word(input int i);
    return 16'(i * 16'h0101) ^ 16'h5a00;
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] be);
    return {be[1] ? d[15:8] : old[15:8], be[0] ? d[7:0] : old[7:0]};
  endfunction

  // behavioural memory
  bit act = 0, hi = 0, stalled = 0;
  int k = 0, base = 0, shown = -1;
  always @(posedge clk) begin
    if (!rst_n) begin
      act = 0;
      mem_wait_n <= 1'b1;
    end else if (mem_cs_n) begin
      act = 0;
      mem_wait_n <= 1'($urandom_range(0, 1));
      mem_dq_i   <= 16'($urandom);
    end else begin
      if (!mem_we_n) begin
        if (!mem_lb_n) marr[mem_addr[5:0]][7:0]  = mem_dq_o[7:0];
        if (!mem_ub_n) marr[mem_addr[5:0]][15:8] = mem_dq_o[15:8];
      end
      if (!act && !mem_adv_n) begin
        act = 1; k = 0; base = int'(mem_addr[5:0]); shown = -1; hi = 0; stalled = 0;
        mem_wait_n <= 1'b0;
      end else if (act) begin
        k++;
        if (shown < 0) begin
          if (k == m_ready_at) begin
            shown = 0; hi = 1;
            mem_wait_n <= 1'b1;
            mem_dq_i   <= marr[base[5:0]];
          end
        end else if (hi) begin
          if (shown + 1 == m_stall && !stalled) begin
            stalled = 1; hi = 0;
            mem_wait_n <= 1'b0;
          end else begin
            shown++;
            mem_wait_n <= 1'b1;
            mem_dq_i   <= marr[6'(base + shown)];
          end
        end else begin
          shown++; hi = 1;
          mem_wait_n <= 1'b1;
          mem_dq_i   <= marr[6'(base + shown)];
        end
      end
    end
  end

  task automatic chk(input bit c, input string r, input longint act_v, input longint exp_v);
    tests++;
    if (!c) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act_v, exp_v);
    end
  endtask

  task automatic do_write(input int a, input logic [15:0] d, input logic [1:0] be);
    bit ok_setup = 1, ok_pulse = 1, ok_hold = 1, ok_end = 1;
    while (!ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = ADDR_W'(a); req_wdata = d; req_be = be;
    @(posedge clk);
    for (int j = 0; j <= WP + 2; j++) begin
      @(negedge clk);
      if (j == 0) begin
        req_valid = 0;
        ok_setup = !mem_cs_n && mem_we_n && (mem_lb_n == !be[0]) && (mem_ub_n == !be[1])
                   && !mem_dq_oe && mem_addr == ADDR_W'(a);
      end else if (j <= WP) begin
        if (!(!mem_cs_n && !mem_we_n && mem_dq_oe && mem_dq_o == d && mem_addr == ADDR_W'(a))) ok_pulse = 0;
      end else if (j == WP + 1) begin
        ok_hold = !mem_cs_n && mem_we_n && mem_dq_oe && mem_dq_o == d && mem_addr == ADDR_W'(a);
      end else begin
        ok_end = mem_cs_n && !mem_dq_oe && mem_lb_n && mem_ub_n && ready;
      end
    end
    chk(ok_setup, "R8 write setup cycle", ok_setup, 1);
    chk(ok_pulse, "R8 WE# low pulse", ok_pulse, 1);
    chk(ok_hold,  "R9 DQ hold cycle", ok_hold, 1);
    chk(ok_end,   "R9 release after write", ok_end, 1);
    expm[a[5:0]] = merge(expm[a[5:0]], d, be);
  endtask

  task automatic do_read(input int a, input int extra, input int stall, input bit expect_cut);
    int first_j = -1, last_j = -1, done_j = -1, nb = 0;
    bit cut = 0, ok_start = 1, ok_adv = 1, ok_dq = 1, ok_turn = 0, ok_data = 1, ok_cs = 1;
    logic [15:0] bad_a = 0, bad_e = 0;
    m_ready_at = expect_cut ? 100000 : 4 + extra;
    m_stall = stall;
    while (!ready) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = ADDR_W'(a);
    @(posedge clk);
    for (int j = 0; j < 400; j++) begin
      @(negedge clk);
      if (j == 0) begin
        req_valid = 0;
        ok_start = !mem_adv_n && !mem_cs_n && !mem_lb_n && !mem_ub_n && mem_we_n && mem_addr == ADDR_W'(a);
      end
      if (j == 1) ok_adv = mem_adv_n && !mem_oe_n && !mem_dq_oe;
      if (mem_dq_oe) ok_dq = 0;
      if (expect_cut && j == MAXC - 1 && mem_cs_n) ok_cs = 0;
      if (expect_cut && j == MAXC && !mem_cs_n) ok_cs = 0;
      if (rd_valid) begin
        if (first_j < 0) first_j = j;
        if (nb < 4 && rd_data != expm[6'(a + nb)]) begin
          ok_data = 0; bad_a = rd_data; bad_e = expm[6'(a + nb)];
        end
        nb++;
        last_j = j;
        if (nb == 4) ok_turn = !ready && mem_cs_n && mem_oe_n;
      end
      if (rd_done) begin
        done_j = j; cut = rd_timeout;
        break;
      end
    end
    chk(ok_start, "R2 ADV#/CS# cycle", ok_start, 1);
    chk(ok_adv, "R2 ADV# single, OE# low", ok_adv, 1);
    chk(ok_dq, "R9 DQ undriven in read", ok_dq, 1);
    if (!expect_cut) begin
      chk(ok_data, "R3 word order/data", bad_a, bad_e);
      chk(nb == 4, "R4 beat count", nb, 4);
      chk(done_j == last_j + 1 && !cut, "R4 done after last beat", done_j, last_j + 1);
      chk(first_j == LAT + 1 + extra, "R6 first beat cycle", first_j, LAT + 1 + extra);
      chk(last_j == first_j + 3 + (stall > 0 ? 1 : 0), "R3 stall shifts beats", last_j,
          first_j + 3 + (stall > 0 ? 1 : 0));
      chk(ok_turn, "R10 turnaround cycle", ok_turn, 1);
    end else begin
      chk(nb == 0, "R7 no beats when WAIT# stays low", nb, 0);
      chk(ok_cs, "R7 CS# released at limit", ok_cs, 1);
      chk(cut && done_j == MAXC + 1, "R7 done+timeout cycle", done_j, MAXC + 1);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog expired (all requirements)");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit ok_idle;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) begin
      marr[i] = init_word(i);
      expm[i] = init_word(i);
    end
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ready && mem_cs_n && mem_adv_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n
        && !mem_dq_oe && !rd_valid && !rd_done, "R1 reset state", ready, 1);
    // R5 WAIT# wiggles while CS# high
    ok_idle = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rd_valid || !mem_cs_n) ok_idle = 0;
    end
    chk(ok_idle, "R5 WAIT# ignored while idle", ok_idle, 1);
    chk(ready, "R1 ready while idle", ready, 1);
    // directed corners
    do_read(0, 0, 0, 0);
    do_write(10, 16'hbeef, 2'b01);
    do_read(8, 0, 0, 0);
    do_write(11, 16'hcafe, 2'b10);
    do_write(12, 16'h1234, 2'b00);
    do_read(10, 2, 2, 0);
    do_read(59, 0, 3, 0);
    do_read(20, 0, 0, 1);
    // R11: write immediately followed by a read
    do_write(30, 16'h5555, 2'b11);
    do_read(30, 0, 1, 0);
    // constrained random mix
    for (int n = 0; n < 80; n++) begin
      int a;
      a = $urandom_range(0, 59);
      if ($urandom_range(0, 2) == 0)
        do_write(a, 16'($urandom), 2'($urandom_range(0, 3)));
      else
        do_read(a, $urandom_range(0, 3), $urandom_range(0, 3), 0);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule